// File: doc/BRIEF.md
# Debug-Mode Entry and Exit Controller

This block decides, cycle by cycle, whether a hart is running normally or is parked in debug mode. It watches four ways in: a halt request that counts only on its rising edge, a reset-time halt request that is looked at once when the hart reset is released, an ebreak that retires in a privilege mode whose ebreak-to-debug enable is set, and a forced entry command. A one-instruction single step is the fifth path. It also watches two ways out: the debug-return instruction and a forced exit command.

On every entry the block raises a one-cycle capture strobe while the debug-mode flag is still low, so the surrounding logic can save the PC and the debug control state before the mode change. The mode flag and the cause code change on the next clock. While in debug mode, an ebreak or an exception does not enter again and does not take a normal trap. It raises a separate redirect strobe so the hart goes back to its debug handler.

All pins are plain control and status levels or single-cycle pulses. No data moves through the block, so no pin carries a valid/ready handshake. Reset is the hart reset itself. It is synchronous and active high.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: While `hart_rst` is high, on the clock after any cycle with `hart_rst` high, `dbg_mode` is 0 and `cause` is 0. During such a cycle `capture`, `step_halt` and `dbg_trap` are 0.
- R2: Outside debug mode, a 0-to-1 change of `halt_req` between two clock samples enters debug mode with cause 3. Holding `halt_req` high causes no further entry until it has been seen low again.
- R3: In the first cycle with `hart_rst` low after a cycle with it high, a high `rst_halt_req` enters debug mode with cause 5. At any other time `rst_halt_req` has no effect.
- R4: Outside debug mode, `ebreak_ret` enters debug mode with cause 1 only if the enable bit for `cur_priv` is set. `cur_priv` 2'b11 (machine) uses `ebk_en[2]`, 2'b01 (supervisor) uses `ebk_en[1]`, and 2'b00 (user) uses `ebk_en[0]`. The value 2'b10 never enters.
- R5: Outside debug mode, `force_wr` with `force_val`=1 enters with cause 2. `force_wr` with `force_val`=0 has no effect there.
- R6: In debug mode, `dret`, or `force_wr` with `force_val`=0, makes `dbg_mode` 0 on the next clock. `cause` keeps its value.
- R7: An exit taken while `step_en` is 1 arms a single step. The first later `insn_ret` outside debug mode enters with cause 4 and pulses `step_halt`. This repeats for every exit taken with `step_en` set. An exit with `step_en` 0 arms nothing.
- R8: In debug mode, `ebreak_ret` or `exc_in_dbg` pulses `dbg_trap` in the same cycle, with no `capture`. In that cycle `dbg_mode` stays 1, `cause` is unchanged and any exit request is dropped.
- R9: When several entry events coincide, the cause is picked in this order: reset halt (5), halt request (3), ebreak (1), forced entry (2), step (4).
- R10: `capture` is high exactly in the cycle an entry is decided, while `dbg_mode` is still 0. `dbg_mode` and `cause` take their new values on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hart_rst | input | 1 | Hart reset, synchronous, active high |
| halt_req | input | 1 | Halt request, acts on its rising edge |
| rst_halt_req | input | 1 | Halt-after-reset request, sampled at reset release |
| ebreak_ret | input | 1 | Pulse: an ebreak retired |
| cur_priv | input | 2 | Current privilege: 3 machine, 1 supervisor, 0 user |
| ebk_en | input | 3 | Ebreak-to-debug enables: [2] machine, [1] supervisor, [0] user |
| step_en | input | 1 | Single-step bit of the debug control register |
| insn_ret | input | 1 | Pulse: a non-debug instruction retired |
| exc_in_dbg | input | 1 | Pulse: exception raised while in debug mode |
| dret | input | 1 | Pulse: debug-return instruction executed |
| force_wr | input | 1 | Pulse: forced write of the debug-mode state |
| force_val | input | 1 | Value of the forced write: 1 enter, 0 leave |
| dbg_mode | output | 1 | Hart is in debug mode |
| capture | output | 1 | Strobe: save PC and debug control state now |
| cause | output | 3 | Cause of the latest entry |
| step_halt | output | 1 | Strobe: entry caused by a completed single step |
| dbg_trap | output | 1 | Strobe: ebreak or exception inside debug mode |

## Verification
A wrong edge memory for the halt request shows up at the ports within a cycle or two. A held request would give a second `capture`, or a fresh edge would give none. A stale step-armed bit gives a `step_halt` on the first retired instruction after an unstepped resume. A wrong priority leaves the wrong `cause` one clock after `capture`. The bench drives the inputs and updates a behavioural model every clock, and compares all five outputs in every cycle. A diverging internal state is therefore reported in the first cycle it reaches a pin.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int PRIV_W  = 2;
  localparam int N_PRIV  = 3;
  localparam int CAUSE_W = 3;
  localparam int N_SRC   = 5;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_EBREAK  = 3'd1,
    CAUSE_TRIGGER = 3'd2,
    CAUSE_HALTREQ = 3'd3,
    CAUSE_STEP    = 3'd4,
    CAUSE_RSTHALT = 3'd5
  } cause_e;

  // entry sources, index 0 has the highest priority
  localparam int SRC_RSTHALT = 0;
  localparam int SRC_HALTREQ = 1;
  localparam int SRC_EBREAK  = 2;
  localparam int SRC_FORCE   = 3;
  localparam int SRC_STEP    = 4;

  function automatic logic [CAUSE_W-1:0] src_code(input int idx);
    case (idx)
      SRC_RSTHALT: src_code = CAUSE_RSTHALT;
      SRC_HALTREQ: src_code = CAUSE_HALTREQ;
      SRC_EBREAK:  src_code = CAUSE_EBREAK;
      SRC_FORCE:   src_code = CAUSE_TRIGGER;
      SRC_STEP:    src_code = CAUSE_STEP;
      default:     src_code = CAUSE_NONE;
    endcase
  endfunction

  // which enable bit serves a privilege level; N_PRIV means none
  function automatic int priv_slot(input logic [PRIV_W-1:0] p);
    case (p)
      2'b11:   priv_slot = 2;
      2'b01:   priv_slot = 1;
      2'b00:   priv_slot = 0;
      default: priv_slot = N_PRIV;
    endcase
  endfunction
endpackage

// File: rtl/dbg_evt_sense.sv
module dbg_evt_sense (
  input  logic clk,
  input  logic hart_rst,
  input  logic halt_req,
  output logic hq_rise,
  output logic rst_fall
);
  logic halt_q;
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q  <= hart_rst;
    halt_q <= hart_rst ? 1'b0 : halt_req;
  end

  assign hq_rise  = halt_req & ~halt_q;
  assign rst_fall = rst_q & ~hart_rst;

  // a rising edge cannot be seen twice in a row
  assert_edge_once_R2: assert property (@(posedge clk) disable iff (hart_rst)
    hq_rise |=> !hq_rise);
  // reset release is only seen right after a reset cycle
  assert_rst_edge_R3: assert property (@(posedge clk) disable iff (hart_rst)
    rst_fall |-> $past(hart_rst));
endmodule

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb #(
  parameter int N = dbg_pkg::N_SRC
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign blocked[i+1] = blocked[i] | req[i];
    assign grant[i]     = req[i] & ~blocked[i];
  end

  assign any = blocked[N];

  always_comb begin
    assert_grant_single_R9: assert ($onehot0(grant));
    assert_grant_any_R9: assert (any == (grant != '0));
  end
endmodule

// File: rtl/dbg_state.sv
module dbg_state
  import dbg_pkg::*;
(
  input  logic               clk,
  input  logic               hart_rst,
  input  logic               enter,
  input  logic               leave,
  input  logic [CAUSE_W-1:0] new_cause,
  input  logic               step_en,
  output logic               dbg_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               arm_q
);
  always_ff @(posedge clk) begin
    if (hart_rst) begin
      dbg_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
      arm_q   <= 1'b0;
    end else if (enter) begin
      dbg_q   <= 1'b1;
      cause_q <= new_cause;
      arm_q   <= 1'b0;
    end else if (leave) begin
      dbg_q   <= 1'b0;
      arm_q   <= step_en;
    end
  end

  // an armed step only exists outside debug mode
  assert_arm_outside_R7: assert property (@(posedge clk) disable iff (hart_rst)
    arm_q |-> !dbg_q);
  // leaving keeps the recorded cause
  assert_leave_cause_R6: assert property (@(posedge clk) disable iff (hart_rst)
    leave |=> $stable(cause_q));
  assert_reset_clear_R1: assert property (@(posedge clk)
    hart_rst |=> (!dbg_q && cause_q == CAUSE_NONE && !arm_q));
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_pkg::*;
(
  input  logic               clk,
  input  logic               hart_rst,
  input  logic               halt_req,
  input  logic               rst_halt_req,
  input  logic               ebreak_ret,
  input  logic [PRIV_W-1:0]  cur_priv,
  input  logic [N_PRIV-1:0]  ebk_en,
  input  logic               step_en,
  input  logic               insn_ret,
  input  logic               exc_in_dbg,
  input  logic               dret,
  input  logic               force_wr,
  input  logic               force_val,
  output logic               dbg_mode,
  output logic               capture,
  output logic [CAUSE_W-1:0] cause,
  output logic               step_halt,
  output logic               dbg_trap
);
  logic               hq_rise, rst_fall;
  logic               dbg_q, arm_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [N_SRC-1:0]   req, grant;
  logic               any_req;
  logic               ebk_ok;
  logic [CAUSE_W-1:0] pick;
  logic               run, leave;

  dbg_evt_sense u_sense (
    .clk      (clk),
    .hart_rst (hart_rst),
    .halt_req (halt_req),
    .hq_rise  (hq_rise),
    .rst_fall (rst_fall)
  );

  always_comb begin
    ebk_ok = 1'b0;
    for (int k = 0; k < N_PRIV; k++)
      if (priv_slot(cur_priv) == k) ebk_ok = ebk_en[k];
  end

  assign run = ~hart_rst & ~dbg_q;

  always_comb begin
    req              = '0;
    req[SRC_RSTHALT] = rst_fall & rst_halt_req;
    req[SRC_HALTREQ] = hq_rise;
    req[SRC_EBREAK]  = ebreak_ret & ebk_ok;
    req[SRC_FORCE]   = force_wr & force_val;
    req[SRC_STEP]    = arm_q & insn_ret;
    req              = run ? req : '0;
  end

  dbg_entry_arb #(.N(N_SRC)) u_arb (
    .req   (req),
    .grant (grant),
    .any   (any_req)
  );

  always_comb begin
    pick = CAUSE_NONE;
    for (int i = 0; i < N_SRC; i++)
      if (grant[i]) pick = pick | src_code(i);
  end

  assign dbg_trap = ~hart_rst & dbg_q & (ebreak_ret | exc_in_dbg);
  assign leave    = ~hart_rst & dbg_q & ~dbg_trap &
                    (dret | (force_wr & ~force_val));

  dbg_state u_state (
    .clk       (clk),
    .hart_rst  (hart_rst),
    .enter     (any_req),
    .leave     (leave),
    .new_cause (pick),
    .step_en   (step_en),
    .dbg_q     (dbg_q),
    .cause_q   (cause_q),
    .arm_q     (arm_q)
  );

  assign dbg_mode  = dbg_q;
  assign cause     = cause_q;
  assign capture   = any_req;
  assign step_halt = grant[SRC_STEP];

  assert_capture_before_R10: assert property (@(posedge clk) disable iff (hart_rst)
    capture |-> !dbg_mode);
  assert_capture_then_mode_R10: assert property (@(posedge clk) disable iff (hart_rst)
    capture |=> (dbg_mode && cause != CAUSE_NONE));
  assert_trap_holds_R8: assert property (@(posedge clk) disable iff (hart_rst)
    dbg_trap |=> (dbg_mode && $stable(cause)));
  assert_step_is_entry_R7: assert property (@(posedge clk) disable iff (hart_rst)
    step_halt |=> (cause == CAUSE_STEP));
  assert_no_dual_strobe_R8: assert property (@(posedge clk) disable iff (hart_rst)
    !(dbg_trap && capture));
endmodule

// File: tb/dbg_mode_ctrl_tb_top.sv
module dbg_mode_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic       hart_rst = 1'b1, halt_req = 1'b0, rst_halt_req = 1'b0;
  logic       ebreak_ret = 1'b0, step_en = 1'b0, insn_ret = 1'b0;
  logic       exc_in_dbg = 1'b0, dret = 1'b0, force_wr = 1'b0, force_val = 1'b0;
  logic [1:0] cur_priv = 2'b11;
  logic [2:0] ebk_en = 3'b000;
  logic       dbg_mode, capture, step_halt, dbg_trap;
  logic [2:0] cause;

  int n_chk = 0, n_bad = 0;

  // behavioural reference state
  bit       m_dbg = 0, m_arm = 0, m_hq = 0, m_rq = 1;
  int       m_cause = 0;

  dbg_mode_ctrl dut_i (
    .clk(clk), .hart_rst(hart_rst), .halt_req(halt_req), .rst_halt_req(rst_halt_req),
    .ebreak_ret(ebreak_ret), .cur_priv(cur_priv), .ebk_en(ebk_en), .step_en(step_en),
    .insn_ret(insn_ret), .exc_in_dbg(exc_in_dbg), .dret(dret), .force_wr(force_wr),
    .force_val(force_val), .dbg_mode(dbg_mode), .capture(capture), .cause(cause),
    .step_halt(step_halt), .dbg_trap(dbg_trap)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // one clock: inputs already set at the falling edge; pulses cleared afterwards
  task automatic cyc(input string tag);
    bit ok_eb, e_cap, e_trap, e_leave, e_step;
    int e_cause;
    #(CLK_P/4);
    ok_eb = (cur_priv == 2'b11 && ebk_en[2]) || (cur_priv == 2'b01 && ebk_en[1]) ||
            (cur_priv == 2'b00 && ebk_en[0]);
    e_cause = 0; e_step = 0;
    if (!hart_rst && !m_dbg) begin
      if (m_rq && rst_halt_req)          e_cause = 5;
      else if (halt_req && !m_hq)        e_cause = 3;
      else if (ebreak_ret && ok_eb)      e_cause = 1;
      else if (force_wr && force_val)    e_cause = 2;
      else if (m_arm && insn_ret) begin  e_cause = 4; e_step = 1; end
    end
    e_cap   = (e_cause != 0);
    e_trap  = !hart_rst && m_dbg && (ebreak_ret || exc_in_dbg);
    e_leave = !hart_rst && m_dbg && !e_trap && (dret || (force_wr && !force_val));
    chk(tag, "dbg_mode", dbg_mode, m_dbg);
    chk(tag, "cause", cause, m_cause);
    chk(tag, "capture", capture, e_cap);
    chk(tag, "step_halt", step_halt, e_step);
    chk(tag, "dbg_trap", dbg_trap, e_trap);
    @(posedge clk);
    if (hart_rst) begin
      m_dbg = 0; m_cause = 0; m_arm = 0;
    end else if (e_cap) begin
      m_dbg = 1; m_cause = e_cause; m_arm = 0;
    end else if (e_leave) begin
      m_dbg = 0; m_arm = step_en;
    end
    m_hq = hart_rst ? 1'b0 : halt_req;
    m_rq = hart_rst;
    @(negedge clk);
    ebreak_ret = 0; insn_ret = 0; exc_in_dbg = 0; dret = 0; force_wr = 0;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1: reset holds everything clear, even with requests present
    halt_req = 1; ebreak_ret = 1; ebk_en = 3'b111; cyc("R1");
    force_wr = 1; force_val = 1; cyc("R1");
    halt_req = 0; ebk_en = 3'b000; idle("R1", 2);

    // R3: reset halt seen at release
    rst_halt_req = 1; hart_rst = 0; cyc("R3");
    cyc("R10"); // now in debug, cause 5
    dret = 1; cyc("R6");
    idle("R3", 3);            // level still high: no effect
    rst_halt_req = 0; idle("R3", 1);
    rst_halt_req = 1; idle("R3", 2);
    rst_halt_req = 0;

    // R2: halt request edge
    halt_req = 1; cyc("R2");
    cyc("R2");
    dret = 1; cyc("R6");
    idle("R2", 3);            // still high: no second entry
    halt_req = 0; cyc("R2");
    halt_req = 1; cyc("R2");  // fresh edge
    halt_req = 0;
    force_wr = 1; force_val = 0; cyc("R6");   // forced exit
    idle("R6", 1);

    // R5: forced write
    force_wr = 1; force_val = 0; cyc("R5");   // ignored outside debug
    idle("R5", 1);
    force_wr = 1; force_val = 1; cyc("R5");
    force_wr = 1; force_val = 1; cyc("R5");   // already in debug
    dret = 1; cyc("R6");

    // R4: ebreak gated by privilege
    ebk_en = 3'b100;
    cur_priv = 2'b01; ebreak_ret = 1; cyc("R4");
    cur_priv = 2'b00; ebreak_ret = 1; cyc("R4");
    cur_priv = 2'b10; ebreak_ret = 1; cyc("R4");
    cur_priv = 2'b11; ebreak_ret = 1; cyc("R4");
    dret = 1; cyc("R6");
    ebk_en = 3'b011;
    cur_priv = 2'b11; ebreak_ret = 1; cyc("R4");
    cur_priv = 2'b01; ebreak_ret = 1; cyc("R4");
    dret = 1; cyc("R6");
    cur_priv = 2'b00; ebreak_ret = 1; cyc("R4");
    ebk_en = 3'b111; cur_priv = 2'b10; ebreak_ret = 1; dret = 1; cyc("R4");

    // R8: traps inside debug mode
    ebreak_ret = 1; cyc("R8");
    exc_in_dbg = 1; dret = 1; cyc("R8");
    exc_in_dbg = 1; force_wr = 1; force_val = 0; cyc("R8");
    halt_req = 1; cyc("R8");  // edge ignored in debug
    halt_req = 0;
    dret = 1; cyc("R6");

    // R7: single step
    force_wr = 1; force_val = 1; cyc("R7");
    step_en = 1; dret = 1; cyc("R7");
    idle("R7", 2);
    insn_ret = 1; cyc("R7");
    cyc("R7");
    dret = 1; cyc("R7");
    insn_ret = 1; cyc("R7");
    step_en = 0; dret = 1; cyc("R7");
    insn_ret = 1; cyc("R7");
    insn_ret = 1; cyc("R7");

    // R9: priorities
    ebk_en = 3'b111; cur_priv = 2'b11;
    halt_req = 1; ebreak_ret = 1; force_wr = 1; force_val = 1; cyc("R9");
    halt_req = 0; dret = 1; cyc("R9");
    ebreak_ret = 1; force_wr = 1; force_val = 1; cyc("R9");
    step_en = 1; dret = 1; cyc("R9");
    force_wr = 1; force_val = 1; insn_ret = 1; cyc("R9");
    step_en = 0; dret = 1; cyc("R9");
    hart_rst = 1; cyc("R1");
    cyc("R1");
    hart_rst = 0; rst_halt_req = 1; halt_req = 1; ebreak_ret = 1; cyc("R9");
    cyc("R9");
    rst_halt_req = 0; halt_req = 0;
    dret = 1; cyc("R6");
    idle("R9", 2);
    finish_run();
  end
endmodule